// File: doc/BRIEF.md
# Looping Scatter-Gather Descriptor Table

This block is a descriptor queue that sits between a register interface and one DMA engine, serving either the memory-write or the memory-read direction. Software builds each descriptor in three writes on a shared 32-bit data bus. The first write stages the low address word. The second stages the length and flag word. The third supplies the high address word and, in the same write, commits the whole descriptor into the table. The table then presents descriptors to the engine over a valid/ready port, one at a time, in the order they were committed.

In program mode each descriptor is handed out once, and the port goes quiet when the table runs dry. In loop mode every descriptor that moves to the engine port is also written back to the tail of the table, so a programmed list repeats without software help. The block reports its fill level, the programming ordinal of the last descriptor the engine accepted, and the number of completed passes over the list. A sticky flag records any commit that was lost because the table was full. A one-cycle clear strobe returns the table and its counters to the empty state.

Top module: `sg_desc_ring`

## Requirements
- R1: A commit builds a descriptor with address = {commit data, staged low word}. From the staged flag word it takes length = bits [23:0], interrupt-disable = bit 24 and last-disable = bit 25. The engine port presents exactly these values.
- R2: In program mode, descriptors reach the engine in commit order, each exactly once. When none remain, descValid stays low.
- R3: In loop mode, every descriptor moved to the engine port is re-queued at the tail. The list therefore repeats indefinitely and the fill level stays constant.
- R4: descValid is low whenever runEnable is low. No descriptor is taken from the table while runEnable is low.
- R5: While descValid is high and descReady is low, the presented descriptor does not change, and descValid stays high as long as runEnable stays high and no clear occurs.
- R6: lastIndex holds the ordinal of the last accepted descriptor. Ordinals count commits from 0, starting after reset or clear.
- R7: passCount increments by one each time a descriptor with ordinal 0 is accepted, except for the first acceptance after reset or clear. It changes at no other time except on a clear.
- R8: The table holds 256 descriptors, not counting the one being presented. A commit into a full table is dropped and sets overflow, which stays set until a clear.
- R9: A clear empties the table and withdraws any presented descriptor. It also zeroes fillLevel, lastIndex, passCount, overflow and the ordinal counter, and it wins over a commit in the same cycle.
- R10: fillLevel counts the descriptors held. This includes a presented descriptor that has not already been re-queued. fillLevel never rises in a cycle without a commit.
- R11: The run mode is sampled when a descriptor moves to the engine port. A descriptor already presented in loop mode has been re-queued, so after a switch to program mode the table drains fully and then stays idle.
- R12: After reset, descValid, fillLevel, lastIndex, passCount and overflow are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrData | input | 32 | Register write data |
| stageLoWe | input | 1 | Stage low address word from wrData |
| stageFlagsWe | input | 1 | Stage length and flags word from wrData |
| commitWe | input | 1 | wrData is the high address word; commit the descriptor |
| tableClear | input | 1 | Empty the table and zero the counters |
| loopMode | input | 1 | 0 = program mode, 1 = loop mode |
| runEnable | input | 1 | Allow descriptors to be issued |
| descValid | output | 1 | Descriptor presented to the engine |
| descReady | input | 1 | Engine accepts the presented descriptor |
| descAddr | output | 64 | Byte address of the descriptor |
| descLen | output | 24 | Byte length |
| descIrqOff | output | 1 | Interrupt-disable flag |
| descLastOff | output | 1 | Last-disable flag |
| fillLevel | output | 9 | Descriptors held |
| lastIndex | output | 16 | Ordinal of the last accepted descriptor |
| passCount | output | 16 | Completed passes over the list |
| overflow | output | 1 | Sticky dropped-commit flag |

## Verification
A wrong read or write pointer would show at the engine port as a descriptor out of order or a repeated one. It would appear on the first acceptance after the fault and would be caught by comparison with the bench's own queue. A wrong occupancy count would show in fillLevel at the next idle point. It would also show as an overflow flag raised too early or too late, or as descValid staying low while entries remain. A bad ordinal tag or pass counter would show in lastIndex or passCount one cycle after the affected acceptance, and in loop mode it would surface within one pass over the list.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

  localparam int IDX_W   = 16;
  localparam int LEN_W   = 24;
  localparam int ADDR_W  = 64;
  localparam int FLAGS_W = LEN_W + 2;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              irqOff;
    logic              lastOff;
    logic [IDX_W-1:0]  idx;
  } descEntry_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic push;     // software commit written at wrPtr
    logic recycle;  // entry at rdPtr copied to wrPtr
    logic load;     // entry at rdPtr moved into the presentation slot
  } ctrlStrb_t;

endpackage

// File: rtl/sgr_datapath.sv
module sgr_datapath
  import sgr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      wrData,
  input  logic             stageLoWe,
  input  logic             stageFlagsWe,
  input  ctrlStrb_t        strb,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic [IDX_W-1:0] commitIdx,
  output descEntry_t       slotEntry
);

  logic [31:0]        loReg;
  logic [FLAGS_W-1:0] flagsReg;
  descEntry_t         mem [DEPTH];
  descEntry_t         headEntry;
  descEntry_t         newEntry;
  descEntry_t         wrEntry;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loReg    <= '0;
      flagsReg <= '0;
    end else begin
      if (stageLoWe)    loReg    <= wrData;
      if (stageFlagsWe) flagsReg <= wrData[FLAGS_W-1:0];
    end
  end

  assign headEntry = mem[rdPtr];

  always_comb begin
    newEntry.addr    = {wrData, loReg};
    newEntry.len     = flagsReg[LEN_W-1:0];
    newEntry.irqOff  = flagsReg[LEN_W];
    newEntry.lastOff = flagsReg[LEN_W+1];
    newEntry.idx     = commitIdx;
    wrEntry          = strb.push ? newEntry : headEntry;
  end

  always_ff @(posedge clk) begin
    if (strb.push || strb.recycle) mem[wrPtr] <= wrEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          slotEntry <= '0;
    else if (strb.load) slotEntry <= headEntry;
  end

endmodule

// File: rtl/sgr_ctrl.sv
module sgr_ctrl
  import sgr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int LVL_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             commitWe,
  input  logic             tableClear,
  input  logic             loopMode,
  input  logic             runEnable,
  input  logic             descReady,
  input  logic [IDX_W-1:0] slotIdx,
  output ctrlStrb_t        strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [IDX_W-1:0] commitIdx,
  output logic             slotValid,
  output logic [LVL_W-1:0] fillLevel,
  output logic [IDX_W-1:0] lastIndex,
  output logic [IDX_W-1:0] passCount,
  output logic             overflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CNT_W-1:0] countQ;
  logic             slotLoop;
  logic             issuedAny;
  logic             handshake;
  logic             canLoad;
  logic             full;

  function automatic logic [PTR_W-1:0] bumpPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  assign full      = (countQ == FULL_CNT);
  assign handshake = slotValid && runEnable && descReady;
  assign canLoad   = runEnable && (countQ != '0) && (!slotValid || handshake)
                     && !commitWe && !tableClear;

  always_comb begin
    strb.push    = commitWe && !tableClear && !full;
    strb.load    = canLoad;
    strb.recycle = canLoad && loopMode;
  end

  assign fillLevel = LVL_W'(countQ) + LVL_W'(slotValid && !slotLoop);

  always_ff @(posedge clk) begin
    if (!rstN || tableClear) begin
      countQ    <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      slotValid <= 1'b0;
      slotLoop  <= 1'b0;
      commitIdx <= '0;
      lastIndex <= '0;
      passCount <= '0;
      issuedAny <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (strb.push || strb.recycle) wrPtr <= bumpPtr(wrPtr);
      if (canLoad)                   rdPtr <= bumpPtr(rdPtr);
      if (strb.push)                 countQ <= countQ + 1'b1;
      else if (canLoad && !loopMode) countQ <= countQ - 1'b1;
      if (strb.push)                 commitIdx <= commitIdx + 1'b1;
      if (commitWe && full)          overflow <= 1'b1;
      if (canLoad) begin
        slotValid <= 1'b1;
        slotLoop  <= loopMode;
      end else if (handshake) begin
        slotValid <= 1'b0;
      end
      if (handshake) begin
        lastIndex <= slotIdx;
        issuedAny <= 1'b1;
        if (slotIdx == '0 && issuedAny) passCount <= passCount + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sg_desc_ring.sv
module sg_desc_ring
  import sgr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      wrData,
  input  logic             stageLoWe,
  input  logic             stageFlagsWe,
  input  logic             commitWe,
  input  logic             tableClear,
  input  logic             loopMode,
  input  logic             runEnable,
  output logic             descValid,
  input  logic             descReady,
  output logic [63:0]      descAddr,
  output logic [23:0]      descLen,
  output logic             descIrqOff,
  output logic             descLastOff,
  output logic [LVL_W-1:0] fillLevel,
  output logic [15:0]      lastIndex,
  output logic [15:0]      passCount,
  output logic             overflow
);

  ctrlStrb_t        strb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [IDX_W-1:0] commitIdx;
  logic             slotValid;
  descEntry_t       slotEntry;

  sgr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .commitWe(commitWe), .tableClear(tableClear),
    .loopMode(loopMode), .runEnable(runEnable), .descReady(descReady),
    .slotIdx(slotEntry.idx), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .commitIdx(commitIdx), .slotValid(slotValid), .fillLevel(fillLevel),
    .lastIndex(lastIndex), .passCount(passCount), .overflow(overflow)
  );

  sgr_datapath #(.DEPTH(DEPTH), .PTR_W(PTR_W)) dp_i (
    .clk(clk), .rstN(rstN), .wrData(wrData), .stageLoWe(stageLoWe),
    .stageFlagsWe(stageFlagsWe), .strb(strb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .commitIdx(commitIdx), .slotEntry(slotEntry)
  );

  assign descValid   = slotValid && runEnable;
  assign descAddr    = slotEntry.addr;
  assign descLen     = slotEntry.len;
  assign descIrqOff  = slotEntry.irqOff;
  assign descLastOff = slotEntry.lastOff;

endmodule

// File: rtl/sg_desc_ring_chk.sv
module sg_desc_ring_chk #(
  parameter int DEPTH = 256,
  parameter int LVL_W = $clog2(DEPTH + 2)
) (
  input logic             clk,
  input logic             rstN,
  input logic             commitWe,
  input logic             tableClear,
  input logic             runEnable,
  input logic             descValid,
  input logic             descReady,
  input logic [63:0]      descAddr,
  input logic [23:0]      descLen,
  input logic [LVL_W-1:0] fillLevel,
  input logic [15:0]      lastIndex,
  input logic [15:0]      passCount,
  input logic             overflow
);

  // R4
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEnable |-> !descValid);

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !descReady && runEnable && !tableClear
    |=> (!runEnable || descValid) && $stable(descAddr) && $stable(descLen));

  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    tableClear |=> fillLevel == '0 && !overflow && passCount == '0 && lastIndex == '0);

  // R8
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillLevel <= LVL_W'(DEPTH + 1));

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !tableClear |=> overflow);

  // R10
  no_growth_chk: assert property (@(posedge clk) disable iff (!rstN)
    !commitWe |=> fillLevel <= $past(fillLevel));

  // R7
  pass_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(descValid && descReady) && !tableClear |=> $stable(passCount));

endmodule

bind sg_desc_ring sg_desc_ring_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
  .clk(clk), .rstN(rstN), .commitWe(commitWe), .tableClear(tableClear),
  .runEnable(runEnable), .descValid(descValid), .descReady(descReady),
  .descAddr(descAddr), .descLen(descLen), .fillLevel(fillLevel),
  .lastIndex(lastIndex), .passCount(passCount), .overflow(overflow)
);

// File: tb/sg_desc_ring_tb_top.sv
module sg_desc_ring_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] wrData = '0;
  logic        stageLoWe = 1'b0, stageFlagsWe = 1'b0, commitWe = 1'b0;
  logic        tableClear = 1'b0, loopMode = 1'b0, runEnable = 1'b0;
  logic        descReady = 1'b0;
  logic        descValid, descIrqOff, descLastOff, overflow;
  logic [63:0] descAddr;
  logic [23:0] descLen;
  logic [8:0]  fillLevel;
  logic [15:0] lastIndex, passCount;

  sg_desc_ring dut_i (.*);

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  int readyPct = 0;
  int issues = 0;
  int issueLimit = 1 << 30;

  // bench model of the queue
  logic [63:0] mAddr [1024];
  logic [25:0] mFlags [1024];
  logic [15:0] mIdx [1024];
  int mHead = 0, mTail = 0;
  bit mLoop = 0, mIssued = 0;
  int mNextIdx = 0, expPass = 0, expIndex = 0;
  bit prevHold = 0;
  logic [63:0] prevAddr;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int mCount();
    return mTail - mHead;
  endfunction

  task automatic mPush(input logic [63:0] a, input logic [25:0] f, input logic [15:0] i);
    mAddr[mTail % 1024] = a; mFlags[mTail % 1024] = f; mIdx[mTail % 1024] = i;
    mTail++;
  endtask

  task automatic mReset();
    mHead = 0; mTail = 0; mIssued = 0; mNextIdx = 0; expPass = 0; expIndex = 0;
  endtask

  task automatic observe();
    int h;
    if (prevHold && runEnable && !tableClear)
      chk(descValid && descAddr == prevAddr, "R5 hold", descAddr, prevAddr);
    prevHold = descValid && !descReady;
    prevAddr = descAddr;
    if (descValid && descReady) begin
      if (mCount() == 0) begin
        chk(0, "R2 unexpected issue", descAddr, 0);
      end else begin
        h = mHead % 1024;
        chk(descAddr == mAddr[h], "R1 addr", descAddr, mAddr[h]);
        chk({descLastOff, descIrqOff, descLen} == mFlags[h], "R1 flags",
            {descLastOff, descIrqOff, descLen}, mFlags[h]);
        expIndex = mIdx[h];
        if (mIdx[h] == 0 && mIssued) expPass++;
        mIssued = 1;
        if (mLoop) mPush(mAddr[h], mFlags[h], mIdx[h]);
        mHead++;
      end
      issues++;
      if (issues >= issueLimit) readyPct = 0;
    end
  endtask

  task automatic step(input bit lo, input bit fl, input bit cm, input bit clr,
                      input logic [31:0] d);
    @(negedge clk);
    stageLoWe = lo; stageFlagsWe = fl; commitWe = cm; tableClear = clr; wrData = d;
    descReady = (($urandom % 100) < readyPct);
    #1;
    observe();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0);
  endtask

  task automatic commit(input logic [31:0] lo, input logic [25:0] fl, input logic [31:0] hi);
    step(1, 0, 0, 0, lo);
    step(0, 1, 0, 0, {6'd0, fl});
    step(0, 0, 1, 0, hi);
    if (mCount() < 256 || runEnable) begin
      mPush({hi, lo}, fl, 16'(mNextIdx));
      mNextIdx++;
    end
  endtask

  task automatic commitRand();
    commit($urandom, 26'($urandom), $urandom);
  endtask

  task automatic clearAll();
    step(0, 0, 0, 1, '0);
    mReset();
    prevHold = 0;
    idle(1);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int sw;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R12 reset state
    chk(!descValid && fillLevel == 0 && lastIndex == 0 && passCount == 0 && !overflow,
        "R12 reset", {descValid, fillLevel, lastIndex, passCount, overflow}, 0);

    // program mode, loaded while disabled
    commit(32'hFFFF_FFFF, 26'h3FF_FFFF, 32'hFFFF_FFFF);
    commit(32'h0, 26'h100_0000, 32'h0);
    for (int i = 0; i < 4; i++) commitRand();
    idle(3);
    chk(fillLevel == 6, "R10 level", fillLevel, 6);
    chk(!descValid, "R4 disabled", descValid, 0);

    runEnable = 1; readyPct = 60;
    idle(60);
    chk(mCount() == 0, "R2 drained", mCount(), 0);
    chk(fillLevel == 0 && !descValid, "R2 empty idle", fillLevel, 0);
    chk(lastIndex == 5, "R6 index", lastIndex, 5);
    chk(passCount == 0, "R7 no pass", passCount, 0);

    for (int i = 0; i < 4; i++) commitRand();
    idle(40);
    chk(mCount() == 0 && lastIndex == 9, "R6 index after refill", lastIndex, 9);

    // clear
    runEnable = 0; readyPct = 0;
    clearAll();
    chk(fillLevel == 0 && lastIndex == 0 && passCount == 0, "R9 clear",
        {fillLevel, lastIndex, passCount}, 0);

    // loop mode
    loopMode = 1; mLoop = 1;
    for (int i = 0; i < 3; i++) commitRand();
    issues = 0; issueLimit = 10;
    runEnable = 1; readyPct = 50;
    for (int i = 0; i < 200 && issues < 10; i++) idle(1);
    idle(6);
    chk(issues == 10, "R3 issue count", issues, 10);
    chk(fillLevel == 3, "R3 level constant", fillLevel, 3);
    chk(passCount == 16'(expPass) && expPass == 3, "R7 passes", passCount, 3);
    chk(lastIndex == 16'(expIndex) && expIndex == 0, "R6 loop index", lastIndex, 0);
    chk(descValid, "R5 presented", descValid, 1);

    // switch to program mode while a loop-loaded descriptor is held
    sw = mCount();
    loopMode = 0; mLoop = 0;
    if (descValid) mPush(mAddr[mHead % 1024], mFlags[mHead % 1024], mIdx[mHead % 1024]);
    issues = 0; issueLimit = 1 << 30; readyPct = 100;
    idle(20);
    chk(issues == sw + 1, "R11 drain count", issues, sw + 1);
    chk(fillLevel == 0 && !descValid, "R11 idle", fillLevel, 0);

    // full table and overflow
    runEnable = 0; readyPct = 0;
    clearAll();
    for (int i = 0; i < 258; i++) commitRand();
    idle(1);
    chk(fillLevel == 256, "R8 full level", fillLevel, 256);
    chk(overflow, "R8 overflow set", overflow, 1);
    runEnable = 1; readyPct = 70;
    idle(400);
    chk(mCount() == 0 && lastIndex == 255, "R8 kept first 256", lastIndex, 255);
    chk(overflow, "R8 sticky", overflow, 1);

    // clear withdraws a presented descriptor
    readyPct = 0;
    commitRand();
    idle(3);
    chk(descValid, "R9 presented before clear", descValid, 1);
    clearAll();
    chk(!descValid && fillLevel == 0 && !overflow, "R9 clear withdraws",
        {descValid, fillLevel, overflow}, 0);

    // clear wins over same-cycle commit
    runEnable = 0;
    step(1, 0, 0, 0, 32'h1);
    step(0, 1, 0, 0, 32'h2);
    @(negedge clk);
    commitWe = 1; tableClear = 1;
    @(negedge clk); commitWe = 0; tableClear = 0; #1;
    chk(fillLevel == 0, "R9 clear over commit", fillLevel, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule